// File: doc/BRIEF.md
# Byte Flash Command Sequencer with Sticky Fast-Program Mode

This block decodes byte-wide bus writes into flash commands and holds the byte array that those commands change. The ordinary program command needs two unlock writes, then a command write, then the address and data. A separate fast-program mode is entered with the same two unlock writes followed by a 20h command. That mode stays active until it is explicitly left. While it is active, each byte needs only two writes: an A0h command and then the address and data.

Each program starts a modelled embedded algorithm that stays busy for a fixed number of clock cycles. While it is busy, a read returns a status byte instead of array data. In that status byte, bit 6 changes on every read and bit 5 reports an error. When the algorithm ends, reads return the array contents again.

A read is requested with `rd_en`. The result appears on `rdata` one clock later, qualified by `rd_valid`.

Top module: `nvm_cmd_engine`

## Requirements
- R1: After reset every array byte reads FFh, `busy` is 0 and the decoder is in normal read mode.
- R2: A normal program is the write sequence AAh at address 555h, 55h at 2AAh, A0h at 555h, then the target address and data. The target byte becomes its old value ANDed with the data. Array index is the low log2(DEPTH) address bits.
- R3: Writing the fourth cycle of a program raises `busy` on the next clock. `busy` stays high for BUSY_CYCLES clocks.
- R4: While `busy` is high, a read returns a status byte. Bit 6 of that byte is inverted on each read, and the first read after a launch returns 1. Bit 5 is the error flag. All other bits read 0.
- R5: The error flag is set when a program asks for a 1 in a bit that currently holds 0. It is cleared by the next write accepted while the block is not busy.
- R6: A write that does not match the expected next cycle of a sequence returns the decoder to read mode (or to fast-program idle when in that mode) without programming.
- R7: AAh at 555h, 55h at 2AAh, then 20h at 555h enters fast-program mode. In that mode, A0h at any address followed by an address/data write programs one byte. The mode persists across programs.
- R8: In fast-program mode, any write other than the A0h program sequence or the 90h/00h exit sequence is refused and changes nothing.
- R9: Writing 90h and then 00h, at any addresses, leaves fast-program mode. A 90h followed by any other value keeps the mode.
- R10: Writes issued while `busy` is high are ignored and do not advance any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Read request |
| addr | input | AW | Byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read result, valid one clock after `rd_en` |
| rd_valid | output | 1 | Marks `rdata` as valid |
| busy | output | 1 | Embedded algorithm in progress |

## Verification
The scenario where a sequence fails to reset after a bad write is the one most likely to go unseen. A decoder left in a stale sequence state shows up only on a later write, when an address/data write programs a byte that should have stayed FFh, or when a valid program fails to start. Each such case is therefore followed at once by a read-back of the targeted byte and by a check of `busy` one clock after the write. A stuck bypass flag shows up on the first bare A0h/data pair issued after the exit sequence. Toggle and error faults show up on the first two status reads after a launch.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
   typedef enum logic [2:0] {
      ST_READ,
      ST_KEY1,
      ST_KEY2,
      ST_PGM_ARM,
      ST_FAST,
      ST_FAST_ARM,
      ST_FAST_EXIT
   } seq_st_e;

   localparam logic [7:0] KEY_A      = 8'hAA;
   localparam logic [7:0] KEY_B      = 8'h55;
   localparam logic [7:0] OP_PROGRAM = 8'hA0;
   localparam logic [7:0] OP_FAST_IN = 8'h20;
   localparam logic [7:0] OP_EXIT1   = 8'h90;
   localparam logic [7:0] OP_EXIT2   = 8'h00;
   localparam int unsigned TOG_BIT   = 6;
   localparam int unsigned ERR_BIT   = 5;
endpackage

// File: rtl/nvm_seq.sv
module nvm_seq
   import nvm_cmd_pkg::*;
#(
   parameter int unsigned AW          = 12,
   parameter logic [11:0] KEY_ADDR_A  = 12'h555,
   parameter logic [11:0] KEY_ADDR_B  = 12'h2AA,
   parameter bit          CHK_OP_ADDR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          busy,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic          launch
);
   localparam int unsigned CW = 12;

   seq_st_e st_q, st_d;
   logic    wr_ok;
   logic    at_a, at_b, op_addr_ok;
   logic [CW-1:0] addr_c;

   assign wr_ok  = wr_en && !busy;
   assign addr_c = CW'(addr);
   assign at_a   = (addr_c == KEY_ADDR_A);
   assign at_b   = (addr_c == KEY_ADDR_B);

   generate
      if (CHK_OP_ADDR) begin : g_op_strict
         assign op_addr_ok = at_a;
      end else begin : g_op_loose
         assign op_addr_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      st_d   = st_q;
      launch = 1'b0;
      if (wr_ok) begin
         unique case (st_q)
            ST_READ:      st_d = (at_a && wdata == KEY_A) ? ST_KEY1 : ST_READ;
            ST_KEY1:      st_d = (at_b && wdata == KEY_B) ? ST_KEY2 : ST_READ;
            ST_KEY2: begin
               if (op_addr_ok && wdata == OP_PROGRAM)      st_d = ST_PGM_ARM;
               else if (op_addr_ok && wdata == OP_FAST_IN) st_d = ST_FAST;
               else                                        st_d = ST_READ;
            end
            ST_PGM_ARM: begin
               launch = 1'b1;
               st_d   = ST_READ;
            end
            ST_FAST: begin
               if (wdata == OP_PROGRAM)    st_d = ST_FAST_ARM;
               else if (wdata == OP_EXIT1) st_d = ST_FAST_EXIT;
               else                        st_d = ST_FAST;
            end
            ST_FAST_ARM: begin
               launch = 1'b1;
               st_d   = ST_FAST;
            end
            ST_FAST_EXIT: st_d = (wdata == OP_EXIT2) ? ST_READ : ST_FAST;
            default:      st_d = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_READ;
      else        st_q <= st_d;
   end

   AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !launch); // R10
   AST_FAST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FAST_ARM && wr_en && !busy) |=> st_q == ST_FAST); // R7
   AST_FAST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FAST) |-> !launch); // R8
endmodule

// File: rtl/nvm_algo.sv
module nvm_algo #(
   parameter int unsigned BUSY_CYCLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  logic       bad_bits,
   input  logic       wr_en,
   input  logic       rd_en,
   output logic       busy,
   output logic [7:0] status_nx
);
   import nvm_cmd_pkg::*;
   localparam int unsigned CNTW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
   localparam logic [CNTW-1:0] CNT_LOAD = CNTW'(BUSY_CYCLES - 1);

   logic [CNTW-1:0] cnt_q;
   logic            busy_q, tog_q, err_q, tog_nx;

   assign busy   = busy_q;
   assign tog_nx = ~tog_q;

   always_comb begin
      status_nx          = '0;
      status_nx[TOG_BIT] = tog_nx;
      status_nx[ERR_BIT] = err_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         tog_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
            tog_q  <= 1'b0;
            err_q  <= bad_bits;
         end else begin
            if (wr_en && !busy_q) err_q <= 1'b0;
            if (busy_q) begin
               if (cnt_q == '0) busy_q <= 1'b0;
               else             cnt_q  <= cnt_q - 1'b1;
               if (rd_en)       tog_q  <= tog_nx;
            end
         end
      end
   end

   AST_BUSY_FROM_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(launch)); // R3
   AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && bad_bits) |=> err_q && busy_q); // R5
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic          bad_bits,
   output logic [7:0]    rd_byte
);
   localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0][7:0] mem_q;
   logic [IW-1:0]         idx;

   assign idx      = addr[IW-1:0];
   assign rd_byte  = mem_q[idx];
   assign bad_bits = |(wdata & ~mem_q[idx]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      end else if (launch) begin
         mem_q[idx] <= mem_q[idx] & wdata;
      end
   end

   AST_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> $stable(mem_q)); // R2
   AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (mem_q[$past(idx)] & ~$past(rd_byte)) == 8'h00); // R2
endmodule

// File: rtl/nvm_cmd_engine.sv
module nvm_cmd_engine #(
   parameter int unsigned AW          = 12,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned BUSY_CYCLES = 8,
   parameter bit          CHK_OP_ADDR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   output logic          rd_valid,
   output logic          busy
);
   generate
      if (AW < 10 || AW > 12) begin : g_bad_aw
         $error("nvm_cmd_engine: AW must be 10..12");
      end
      if (DEPTH < 2 || DEPTH > 1024 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("nvm_cmd_engine: DEPTH must be a power of two in 2..1024");
      end
      if (DEPTH > (1 << AW)) begin : g_bad_fit
         $error("nvm_cmd_engine: DEPTH exceeds address space");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("nvm_cmd_engine: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic       launch, bad_bits;
   logic [7:0] status_nx, rd_byte;

   nvm_seq #(
      .AW          (AW),
      .CHK_OP_ADDR (CHK_OP_ADDR)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .busy   (busy),
      .addr   (addr),
      .wdata  (wdata),
      .launch (launch)
   );

   nvm_algo #(
      .BUSY_CYCLES (BUSY_CYCLES)
   ) u_algo (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .bad_bits  (bad_bits),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .busy      (busy),
      .status_nx (status_nx)
   );

   nvm_array #(
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .addr     (addr),
      .wdata    (wdata),
      .bad_bits (bad_bits),
      .rd_byte  (rd_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rdata    <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= busy ? status_nx : rd_byte;
      end
   end

   AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (rdata & 8'h9F) == 8'h00); // R4
   AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && $past(rd_en && busy)) |=> rdata[6] != $past(rdata[6])); // R4
endmodule

// File: tb/test_nvm_cmd_engine.sv
module test_nvm_cmd_engine;
   localparam int unsigned AW   = 12;
   localparam int unsigned BUSY = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          rd_valid, busy;

   int total = 0, bad = 0;
   bit done = 0;

   logic [7:0]  exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   nvm_cmd_engine #(.AW(AW), .BUSY_CYCLES(BUSY)) i_nvm_cmd_engine (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .busy(busy));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic unlock();
      wr(12'h555, 8'hAA);
      wr(12'h2AA, 8'h55);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops scoreboard entries as results appear
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard: unexpected read result %h expected none", rdata);
         end else begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 busy after reset", {7'd0, busy}, 8'h00);
      rd(12'h003, 8'hFF, "R1 erased byte");

      // R2/R3/R4 normal program
      unlock(); wr(12'h555, 8'hA0); wr(12'h003, 8'h5A);
      check("R3 busy next clock", {7'd0, busy}, 8'h01);
      rd(12'h003, 8'h40, "R4 status first read");
      rd(12'h003, 8'h00, "R4 status second read");
      rd(12'h003, 8'h40, "R4 status third read");
      idle(BUSY);
      check("R3 busy ended", {7'd0, busy}, 8'h00);
      rd(12'h003, 8'h5A, "R2 programmed byte");

      // R5 error when raising a 0 bit, AND result
      unlock(); wr(12'h555, 8'hA0); wr(12'h003, 8'hFF);
      rd(12'h003, 8'h60, "R5 error status first");
      rd(12'h003, 8'h20, "R5 error status second");
      idle(BUSY);
      rd(12'h003, 8'h5A, "R5 byte unchanged by 1-bits");
      unlock(); wr(12'h555, 8'hA0); wr(12'h004, 8'h0F);
      rd(12'h004, 8'h40, "R5 error cleared by next command");
      idle(BUSY);
      rd(12'h004, 8'h0F, "R2 second program");

      // R6 broken sequence
      wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'hA0); wr(12'h006, 8'h00);
      check("R6 no busy after broken unlock", {7'd0, busy}, 8'h00);
      rd(12'h006, 8'hFF, "R6 no program after broken unlock");
      unlock(); wr(12'h555, 8'h33); wr(12'h006, 8'h00);
      rd(12'h006, 8'hFF, "R6 bad command byte");

      // R7 fast mode, two bytes
      unlock(); wr(12'h555, 8'h20);
      wr(12'h0F0, 8'hA0); wr(12'h007, 8'h3C);
      check("R7 fast program busy", {7'd0, busy}, 8'h01);
      rd(12'h007, 8'h40, "R7 fast status");
      idle(BUSY);
      rd(12'h007, 8'h3C, "R7 fast byte one");
      wr(12'h123, 8'hA0); wr(12'h008, 8'hC3);
      idle(BUSY + 1);
      rd(12'h008, 8'hC3, "R7 fast byte two sticky");

      // R8 refused writes in fast mode
      wr(12'h009, 8'h00);
      check("R8 bare write no busy", {7'd0, busy}, 8'h00);
      rd(12'h009, 8'hFF, "R8 bare write refused");
      unlock(); wr(12'h555, 8'h20); wr(12'h00B, 8'h00);
      rd(12'h00B, 8'hFF, "R8 normal sequence refused");

      // R9 90h then non-00h keeps fast mode
      wr(12'h000, 8'h90); wr(12'h000, 8'h11);
      wr(12'h000, 8'hA0); wr(12'h00A, 8'h55);
      idle(BUSY + 1);
      rd(12'h00A, 8'h55, "R9 mode kept after bad exit");
      // R9 exit at arbitrary addresses
      wr(12'h123, 8'h90); wr(12'h456, 8'h00);
      wr(12'h000, 8'hA0); wr(12'h00B, 8'h00);
      check("R9 no fast program after exit", {7'd0, busy}, 8'h00);
      rd(12'h00B, 8'hFF, "R9 exited fast mode");
      unlock(); wr(12'h555, 8'hA0); wr(12'h00B, 8'h81);
      idle(BUSY + 1);
      rd(12'h00B, 8'h81, "R9 normal program after exit");

      // R10 writes during busy ignored
      unlock(); wr(12'h555, 8'hA0); wr(12'h00C, 8'h0F);
      unlock(); wr(12'h555, 8'hA0); wr(12'h00D, 8'h00);
      idle(BUSY);
      check("R10 busy cleared", {7'd0, busy}, 8'h00);
      rd(12'h00D, 8'hFF, "R10 write during busy ignored");
      rd(12'h00C, 8'h0F, "R10 running program done");
      wr(12'h00D, 8'h00);
      rd(12'h00D, 8'hFF, "R10 no sequence carried over");

      idle(3);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard: %0d reads missing expected 0", exp_q.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1;
      $finish;
   end
endmodule